// File: doc/BRIEF.md
# Sixteen-Bit Timer with Compare-Match Period Reset

This block is a 16-bit up-counter for use as a peripheral behind a byte-wide register bus. It can count either a free-running internal clock enable or rising edges on an external input. The external input normally passes through a synchronizer, and a control bit can bypass it. A prescaler selected by two control bits divides the count source by 1, 2, 4 or 8.

A rollover from all ones to zero sets a sticky overflow flag. A compare unit holds a 16-bit compare value and a 4-bit mode field. When the mode selects reset-on-match, a match after an increment fires a one-cycle trigger that clears the counter, so the compare value behaves as a period register. The trigger sets its own compare flag and never the overflow flag. Either flag can drive the interrupt output through its own enable bit.

There are two resets. The power-on/brown-out reset clears the control byte, which stops the timer and selects 1:1 prescale. The other reset leaves the control byte alone. Neither reset touches the count bytes.

Top module: `tmr16_cmp`

## Requirements
- R1: The bus map is: address 0 control, 1 count low byte, 2 count high byte, 3 compare low byte, 4 compare high byte, 5 compare mode (bits 3:0), 6 flags (bit 0 overflow, bit 1 compare), 7 interrupt enables (bit 0 overflow, bit 1 compare). Control bits are: 0 run, 1 external source, 2 synchronizer bypass, 3 oscillator enable (stored only), 5:4 prescale select. Control bits 7:6 read as 0.
- R2: When rst_por_n is low, the control byte reads 00h. When rst_sys_n is low, the control byte keeps its value.
- R3: Neither reset input changes the count value.
- R4: With the run bit set and the external-source bit clear, each cycle with tick_en high is one source pulse. Prescale select 00, 01, 10 and 11 gives one increment per 1, 2, 4 and 8 source pulses. With the run bit clear the count holds.
- R5: A write to count address 1 or 2 clears the prescaler. The next increment then needs a full prescale period of source pulses.
- R6: With compare mode 4'b1011, a count equal to the compare value right after an increment drives match_trig_o high for exactly one cycle. The count is zero on the next cycle, and compare flag bit 1 is set.
- R7: A compare-match clear never sets overflow flag bit 0, even when the compare value is FFFFh.
- R8: An increment from FFFFh to 0000h sets overflow flag bit 0, and the flag stays set. Writing the flags register loads its bits, so writing 0 clears them. irq_o is high when a set flag has its enable bit set.
- R9: A count-byte write in the same cycle as a match trigger wins: the written byte is loaded, and the trigger clears nothing.
- R10: With the external-source bit set, each rising edge of ext_in counts as one source pulse. Through the two-flop synchronizer, ext_in high lasting 3 cycles and low lasting 3 cycles gives one pulse per period. With the synchronizer bypass bit set, the edge is taken directly from ext_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_por_n | input | 1 | Power-on/brown-out reset, active low, asynchronous |
| rst_sys_n | input | 1 | Other reset, active low, asynchronous; control byte kept |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| tick_en | input | 1 | Internal timer clock enable |
| ext_in | input | 1 | External count input |
| count_o | output | 16 | Current count value |
| match_trig_o | output | 1 | One-cycle compare-match trigger |
| irq_o | output | 1 | Interrupt request |

## Verification
Three pairs of events can fall in the same cycle: a count-byte write with a compare-match trigger, the trigger with a pending increment at FFFFh, and a flag write with a flag set. The bench loads the count with one below the compare value at 1:1 prescale. It then writes a new low byte in exactly the cycle the trigger is raised, and expects the written byte rather than zero. It also sets the compare value to FFFFh and expects the compare flag set with the overflow flag clear. A behavioural reference model runs alongside and judges count, trigger and interrupt on every cycle.

// File: rtl/tmr16_pkg.sv
`timescale 1ns/1ps
package tmr16_pkg;
  localparam int BUS_W  = 8;
  localparam int ADDR_W = 3;
  localparam int PS_W   = 2;
  localparam int PRE_W  = (1 << PS_W) - 1;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMP_LO = 3'd3;
  localparam logic [ADDR_W-1:0] A_MODE   = 3'd5;
  localparam logic [ADDR_W-1:0] A_FLAG   = 3'd6;
  localparam logic [ADDR_W-1:0] A_IEN    = 3'd7;

  localparam logic [3:0] MODE_PERIOD_RESET = 4'b1011;

  // bit order matches the control byte: [5:4] psel, [3] osc, [2] bypass, [1] ext, [0] run
  typedef struct packed {
    logic [PS_W-1:0] psel;
    logic            osc_en;
    logic            no_sync;
    logic            ext_src;
    logic            run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/tmr16_regs.sv
`timescale 1ns/1ps
module tmr16_regs
  import tmr16_pkg::*;
#(
  parameter int BW = BUS_W,
  localparam int CW = 2 * BW
) (
  input  logic              clk,
  input  logic              rst_por_n,
  input  logic              rst_any_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BW-1:0]     wdata,
  output ctrl_t             ctrl_o,
  output logic [CW-1:0]     cmp_o,
  output logic [3:0]        mode_o,
  output logic [1:0]        ien_o
);
  ctrl_t         ctrl_q, ctrl_d;
  logic [CW-1:0] cmp_q,  cmp_d;
  logic [3:0]    mode_q, mode_d;
  logic [1:0]    ien_q,  ien_d;
  logic          wr_ctrl;

  assign wr_ctrl = wr && (addr == A_CTRL);

  always_comb begin
    ctrl_d = ctrl_q;
    mode_d = mode_q;
    ien_d  = ien_q;
    cmp_d  = cmp_q;
    if (wr_ctrl)               ctrl_d = ctrl_t'(wdata[CTRL_W-1:0]);
    if (wr && addr == A_MODE)  mode_d = wdata[3:0];
    if (wr && addr == A_IEN)   ien_d  = wdata[1:0];
    for (int b = 0; b < 2; b++)
      if (wr && addr == A_CMP_LO + ADDR_W'(b)) cmp_d[b*BW +: BW] = wdata;
  end

  // control byte: only the power-on/brown-out reset clears it
  always_ff @(posedge clk or negedge rst_por_n) begin
    if (!rst_por_n) ctrl_q <= '0;
    else            ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_any_n) begin
    if (!rst_any_n) begin
      cmp_q  <= '0;
      mode_q <= '0;
      ien_q  <= '0;
    end else begin
      cmp_q  <= cmp_d;
      mode_q <= mode_d;
      ien_q  <= ien_d;
    end
  end

  assign ctrl_o = ctrl_q;
  assign cmp_o  = cmp_q;
  assign mode_o = mode_q;
  assign ien_o  = ien_q;

  // R2: the other reset input never disturbs the control byte
  assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (!rst_por_n)
    !wr_ctrl |=> $stable(ctrl_q));
endmodule

// File: rtl/tmr16_src.sv
`timescale 1ns/1ps
module tmr16_src
  import tmr16_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            ext_src,
  input  logic            no_sync,
  input  logic [PS_W-1:0] psel,
  input  logic            tick_en,
  input  logic            ext_in,
  input  logic            cnt_wr,
  output logic            tick
);
  logic [SYNC_N-1:0] sync_q, sync_d;
  logic              sprev_q, raw_q;
  logic [PRE_W-1:0]  pre_q, pre_d, lim;
  logic              edge_sync, edge_raw, src_pulse, at_lim;

  generate
    if (SYNC_N == 1) begin : g_sync1
      assign sync_d = ext_in;
    end else begin : g_syncn
      assign sync_d = {sync_q[SYNC_N-2:0], ext_in};
    end
  endgenerate

  assign lim       = PRE_W'((1 << psel) - 1);
  assign edge_sync = sync_q[SYNC_N-1] & ~sprev_q;
  assign edge_raw  = ext_in & ~raw_q;
  assign src_pulse = ext_src ? (no_sync ? edge_raw : edge_sync) : tick_en;
  assign at_lim    = (pre_q >= lim);
  assign tick      = run & src_pulse & at_lim;

  always_comb begin
    pre_d = pre_q;
    if (cnt_wr)                pre_d = '0;
    else if (run && src_pulse) pre_d = at_lim ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      sprev_q <= 1'b0;
      raw_q   <= 1'b0;
      pre_q   <= '0;
    end else begin
      sync_q  <= sync_d;
      sprev_q <= sync_q[SYNC_N-1];
      raw_q   <= ext_in;
      pre_q   <= pre_d;
    end
  end

  // R5: a count write leaves the prescaler empty
  assert_prescale_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (pre_q == '0));
  // R4: with the run bit clear no increment is issued
  assert_idle_no_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick);
endmodule

// File: rtl/tmr16_core.sv
`timescale 1ns/1ps
module tmr16_core
  import tmr16_pkg::*;
#(
  parameter int BW = BUS_W,
  localparam int CW = 2 * BW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BW-1:0]     wdata,
  input  logic              tick,
  input  logic [CW-1:0]     cmp,
  input  logic [3:0]        mode,
  output logic              cnt_wr,
  output logic [CW-1:0]     cnt_o,
  output logic              trig_o,
  output logic              ovf_o,
  output logic              cmpf_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          incd_q, incd_d;
  logic          ovf_q, ovf_d, cmpf_q, cmpf_d;
  logic          trig, ovf_set, flag_wr, lo_wr;

  assign lo_wr   = wr && (addr == A_CNT_LO);
  assign cnt_wr  = wr && (addr == A_CNT_LO || addr == A_CNT_HI);
  assign flag_wr = wr && (addr == A_FLAG);
  assign trig    = (mode == MODE_PERIOD_RESET) && incd_q && (cnt_q == cmp);
  assign ovf_set = tick && (&cnt_q) && !trig && !cnt_wr;

  always_comb begin
    if (trig)      cnt_d = '0;
    else if (tick) cnt_d = cnt_q + 1'b1;
    else           cnt_d = cnt_q;
    // a bus write beats both the match clear and the increment
    for (int b = 0; b < 2; b++)
      if (wr && addr == A_CNT_LO + ADDR_W'(b)) cnt_d[b*BW +: BW] = wdata;
    incd_d = tick && !trig && !cnt_wr;
    ovf_d  = (flag_wr ? wdata[0] : ovf_q)  | ovf_set;
    cmpf_d = (flag_wr ? wdata[1] : cmpf_q) | trig;
  end

  // count bytes carry no reset at all
  always_ff @(posedge clk) begin
    cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      incd_q <= 1'b0;
      ovf_q  <= 1'b0;
      cmpf_q <= 1'b0;
    end else begin
      incd_q <= incd_d;
      ovf_q  <= ovf_d;
      cmpf_q <= cmpf_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign trig_o = trig;
  assign ovf_o  = ovf_q;
  assign cmpf_o = cmpf_q;

  // R6: the trigger clears the count and lasts one cycle
  assert_match_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !cnt_wr) |=> (cnt_q == '0));
  assert_trig_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !trig);
  // R7: a match clear does not raise the overflow flag
  assert_match_no_ovf_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !ovf_q && !flag_wr) |=> !ovf_q);
  // R9: the written low byte survives a coincident trigger
  assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && lo_wr) |=> (cnt_q[BW-1:0] == $past(wdata)));
endmodule

// File: rtl/tmr16_cmp.sv
`timescale 1ns/1ps
module tmr16_cmp
  import tmr16_pkg::*;
#(
  parameter int BW     = BUS_W,
  parameter int SYNC_N = 2,
  localparam int CW    = 2 * BW
) (
  input  logic              clk,
  input  logic              rst_por_n,
  input  logic              rst_sys_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BW-1:0]     bus_wdata,
  output logic [BW-1:0]     bus_rdata,
  input  logic              tick_en,
  input  logic              ext_in,
  output logic [CW-1:0]     count_o,
  output logic              match_trig_o,
  output logic              irq_o
);
  logic          rst_any_n;
  ctrl_t         ctrl;
  logic [CW-1:0] cmp, cnt;
  logic [3:0]    mode;
  logic [1:0]    ien;
  logic          tick, cnt_wr, trig, ovf, cmpf;

  assign rst_any_n = rst_por_n & rst_sys_n;

  tmr16_regs #(.BW(BW)) u_regs (
    .clk(clk), .rst_por_n(rst_por_n), .rst_any_n(rst_any_n),
    .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .ctrl_o(ctrl), .cmp_o(cmp), .mode_o(mode), .ien_o(ien)
  );

  tmr16_src #(.SYNC_N(SYNC_N)) u_src (
    .clk(clk), .rst_n(rst_any_n), .run(ctrl.run), .ext_src(ctrl.ext_src),
    .no_sync(ctrl.no_sync), .psel(ctrl.psel), .tick_en(tick_en),
    .ext_in(ext_in), .cnt_wr(cnt_wr), .tick(tick)
  );

  tmr16_core #(.BW(BW)) u_core (
    .clk(clk), .rst_n(rst_any_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .tick(tick), .cmp(cmp), .mode(mode),
    .cnt_wr(cnt_wr), .cnt_o(cnt), .trig_o(trig), .ovf_o(ovf), .cmpf_o(cmpf)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:   bus_rdata = BW'(ctrl);
      A_CNT_LO: bus_rdata = cnt[BW-1:0];
      A_CNT_HI: bus_rdata = cnt[CW-1:BW];
      3'd3:     bus_rdata = cmp[BW-1:0];
      3'd4:     bus_rdata = cmp[CW-1:BW];
      A_MODE:   bus_rdata = BW'(mode);
      A_FLAG:   bus_rdata = BW'({cmpf, ovf});
      A_IEN:    bus_rdata = BW'(ien);
      default:  bus_rdata = '0;
    endcase
  end

  assign count_o      = cnt;
  assign match_trig_o = trig;
  assign irq_o        = (ovf & ien[0]) | (cmpf & ien[1]);

  // R8: an interrupt needs a set flag with its enable
  assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_any_n)
    irq_o |-> ((ovf && ien[0]) || (cmpf && ien[1])));
endmodule

// File: tb/tmr16_cmp_tb.sv
`timescale 1ns/1ps
module tmr16_cmp_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_por_n = 1'b0, rst_sys_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        tick_en = 1'b0, ext_in = 1'b0;
  logic [15:0] count_o;
  logic        match_trig_o, irq_o;

  int checks = 0, errors = 0;
  bit cmp_on = 0;

  // reference model state
  logic [7:0]  m_ctrl = 0;
  logic [15:0] m_cnt = 0, m_cmp = 0;
  logic [3:0]  m_mode = 0;
  logic [1:0]  m_ien = 0;
  int          m_pre = 0;
  logic        m_s0 = 0, m_s1 = 0, m_sp = 0, m_raw = 0, m_incd = 0, m_ovf = 0, m_cmpf = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr16_cmp u_dut (
    .clk(clk), .rst_por_n(rst_por_n), .rst_sys_n(rst_sys_n),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_en(tick_en), .ext_in(ext_in), .count_o(count_o),
    .match_trig_o(match_trig_o), .irq_o(irq_o)
  );

  function automatic bit model_trig();
    return rst_por_n && rst_sys_n && m_mode == 4'b1011 && m_incd && m_cnt == m_cmp;
  endfunction

  always @(posedge clk) begin
    bit trg, src, tk, cw, inr;
    int lim;
    logic [15:0] nc;
    inr = !(rst_por_n && rst_sys_n);
    trg = model_trig();
    src = m_ctrl[1] ? (m_ctrl[2] ? (ext_in && !m_raw) : (m_s1 && !m_sp)) : tick_en;
    lim = (1 << m_ctrl[5:4]) - 1;
    cw  = bus_wr && (bus_addr == 1 || bus_addr == 2);
    tk  = m_ctrl[0] && src && (m_pre >= lim);
    nc  = trg ? 16'h0 : (tk ? m_cnt + 16'h1 : m_cnt);
    if (bus_wr && bus_addr == 1) nc[7:0]  = bus_wdata;
    if (bus_wr && bus_addr == 2) nc[15:8] = bus_wdata;
    if (tk && m_cnt == 16'hFFFF && !trg && !cw) m_ovf = 1;
    else if (bus_wr && bus_addr == 6) m_ovf = bus_wdata[0];
    if (trg) m_cmpf = 1;
    else if (bus_wr && bus_addr == 6) m_cmpf = bus_wdata[1];
    if (cw) m_pre = 0;
    else if (m_ctrl[0] && src) m_pre = (m_pre >= lim) ? 0 : m_pre + 1;
    m_incd = tk && !trg && !cw;
    m_cnt = nc;
    if (bus_wr && bus_addr == 0) m_ctrl = {2'b00, bus_wdata[5:0]};
    if (bus_wr && bus_addr == 3) m_cmp[7:0]  = bus_wdata;
    if (bus_wr && bus_addr == 4) m_cmp[15:8] = bus_wdata;
    if (bus_wr && bus_addr == 5) m_mode = bus_wdata[3:0];
    if (bus_wr && bus_addr == 7) m_ien = bus_wdata[1:0];
    m_sp = m_s1; m_s1 = m_s0; m_s0 = ext_in; m_raw = ext_in;
    if (!rst_por_n) m_ctrl = 0;
    if (inr) begin
      m_pre = 0; m_s0 = 0; m_s1 = 0; m_sp = 0; m_raw = 0; m_incd = 0;
      m_ovf = 0; m_cmpf = 0; m_cmp = 0; m_mode = 0; m_ien = 0;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_on) begin
      check("R4 count", count_o, m_cnt);
      check("R6 trigger", match_trig_o, model_trig());
      check("R8 irq", irq_o, (m_ovf & m_ien[0]) | (m_cmpf & m_ien[1]));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick_en = 1;
    @(negedge clk); tick_en = 0;
  endtask

  task automatic ext_pulses(input int n, input int half);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext_in = 1; idle(half - 1);
      @(negedge clk); ext_in = 0; idle(half - 1);
    end
  endtask

  logic [7:0]  rv;
  logic [15:0] snap;

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_por_n = 1; rst_sys_n = 1;
    // R2: reset state of the control byte; R1 flags and enables clear
    rd(0, rv); check("R2 ctrl after POR", rv, 8'h00);
    rd(6, rv); check("R1 flags after reset", rv, 8'h00);
    rd(7, rv); check("R1 enables after reset", rv, 8'h00);
    wr(2, 8'h00); wr(1, 8'h00);
    cmp_on = 1;
    // R1: bits 7:6 read zero
    wr(0, 8'hC8); rd(0, rv); check("R1 ctrl upper bits", rv, 8'h08);
    // R4: idle while run clear
    tick_en = 1; idle(5); check("R4 hold when off", count_o, 16'h0000);
    // R4: 1:1 then 1:4 with irregular enable
    wr(0, 8'h01); idle(10);
    wr(0, 8'h21);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk); tick_en = ((i * 7) % 5) < 3;
    end
    wr(0, 8'h31); tick_en = 1; idle(40);
    // R5: prescaler cleared by a count write (1:8)
    tick_en = 0;
    wr(2, 8'h10); wr(1, 8'h00);
    for (int i = 0; i < 5; i++) pulse_tick();
    wr(1, 8'h00);
    for (int i = 0; i < 7; i++) pulse_tick();
    check("R5 no step after 7 pulses", count_o, 16'h1000);
    pulse_tick();
    check("R5 step on 8th pulse", count_o, 16'h1001);
    // R8: overflow flag and irq
    wr(0, 8'h01); wr(7, 8'h01); tick_en = 1;
    wr(2, 8'hFF); wr(1, 8'hF0); idle(25);
    rd(6, rv); check("R8 overflow flag", rv & 1, 1);
    check("R8 irq with enable", irq_o, 1);
    wr(6, 8'h00); rd(6, rv); check("R8 flag cleared", rv & 1, 0);
    check("R8 irq cleared", irq_o, 0);
    // R6: period reset at 0x0010
    wr(7, 8'h02); wr(4, 8'h00); wr(3, 8'h10); wr(5, 8'h0B);
    wr(2, 8'h00); wr(1, 8'h00); idle(40);
    rd(6, rv); check("R6 compare flag", rv, 8'h02);
    check("R6 count below period", count_o <= 16'h0010, 1);
    // R9: write coincides with trigger
    wr(1, 8'h0F); // count becomes 000F, increments to 0010, trigger follows
    wr(1, 8'h55);
    check("R9 write wins", count_o, 16'h0055);
    // R7: compare at FFFF
    wr(6, 8'h00); wr(4, 8'hFF); wr(3, 8'hFF);
    wr(2, 8'hFF); wr(1, 8'hF0); idle(30);
    rd(6, rv); check("R7 no overflow on match clear", rv, 8'h02);
    // R10: synchronized external edges
    wr(5, 8'h00); tick_en = 0;
    wr(0, 8'h03); wr(2, 8'h20); wr(1, 8'h00);
    ext_pulses(4, 3); idle(4);
    check("R10 synced edges", count_o, 16'h2004);
    wr(0, 8'h07); wr(1, 8'h00);
    ext_pulses(3, 2); idle(2);
    check("R10 bypass edges", count_o, 16'h2003);
    // R2/R3: resets
    wr(0, 8'h3C); snap = count_o;
    @(negedge clk); rst_sys_n = 0; idle(2); @(negedge clk); rst_sys_n = 1;
    rd(0, rv); check("R2 ctrl kept by sys reset", rv, 8'h3C);
    check("R3 count kept by sys reset", count_o, snap);
    @(negedge clk); rst_por_n = 0; idle(2); @(negedge clk); rst_por_n = 1;
    rd(0, rv); check("R2 ctrl cleared by POR", rv, 8'h00);
    check("R3 count kept by POR", count_o, snap);
    idle(3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule